// File: doc/BRIEF.md
# Instruction Prefix and Operand-Size Decoder

This block sits at the front of an instruction decoder and looks at an instruction's leading bytes, one byte per clock. It sorts each byte into a legacy prefix, a register-extension prefix or the opcode. When the opcode byte arrives, it reports the extension bits and the effective operand and address sizes that the prefixes select. The result depends on the current execution mode: 64-bit, compatibility or legacy.

The byte stream has a valid qualifier and a start-of-instruction marker. The marker clears all prefix state. The extension prefix is any byte from 0x40 to 0x4F, and it is honoured only in 64-bit mode. It applies only when the opcode follows it directly. A legacy prefix placed after it discards it, and when several appear, the last one before the opcode is the one used. A side input marks instructions that use the stack implicitly; in 64-bit mode these default to a 64-bit operand. The opcode must appear within 15 bytes. If the 16th byte of an instruction arrives with no opcode seen yet, a length fault is raised. Bytes after the opcode or after a fault are ignored until the next start marker.

Top module: `pfx_size_decoder`

## Requirements
- R1: After reset, `opc_stb_o` and `len_fault_o` are low and the four extension bits read 0.
- R2: With no prefixes, the operand size is 32 bits in every mode. The address size is 64 bits in 64-bit mode and 32 bits otherwise. Mode codes are 00 legacy, 01 compatibility, 10 64-bit. Size codes are 01 = 16, 10 = 32, 11 = 64.
- R3: A 66H prefix selects a 16-bit operand. A 67H prefix selects a 32-bit address in 64-bit mode and a 16-bit address in the other modes, so no 16-bit address is produced in 64-bit mode.
- R4: In 64-bit mode, a byte 0x40..0x4F placed directly before the opcode is reported as W = bit 3, R = bit 2, X = bit 1, B = bit 0. With W = 1 the operand size is 64 bits even when 66H is present.
- R5: An extension byte that is followed by a legacy prefix is discarded. When several extension bytes appear, only the last one before the opcode takes effect.
- R6: In legacy and compatibility modes, a byte 0x40..0x4F is an opcode: it raises the strobe, and the extension bits read 0.
- R7: In 64-bit mode, an instruction flagged as stack-implicit gets a 64-bit operand by default and a 16-bit operand with 66H, unless W = 1 (then 64). It never gets 32 bits. Outside 64-bit mode the flag has no effect.
- R8: If the 16th byte of an instruction arrives before an opcode, `len_fault_o` pulses for one cycle and no strobe follows for that instruction. An opcode at byte 15 or earlier decodes normally.
- R9: The results appear, and `opc_stb_o` pulses for exactly one cycle, in the cycle after the opcode byte is accepted. Bytes that follow, up to the next start marker, cause no strobe and no fault.
- R10: A start marker discards the prefix state of an unfinished instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_vld_i | input | 1 | Byte lane holds a valid byte |
| byte_sop_i | input | 1 | Valid byte is the first of an instruction |
| byte_i | input | 8 | Instruction byte |
| cpu_mode_i | input | 2 | 00 legacy, 01 compatibility, 10 64-bit |
| stack_op_i | input | 1 | Opcode byte belongs to a stack-implicit instruction |
| rex_w_o | output | 1 | Operand-width extension bit |
| rex_r_o | output | 1 | Register-field extension bit |
| rex_x_o | output | 1 | Index extension bit |
| rex_b_o | output | 1 | Base/rm extension bit |
| opnd_size_o | output | 2 | Effective operand size code |
| addr_size_o | output | 2 | Effective address size code |
| opc_stb_o | output | 1 | One-cycle pulse: results valid |
| len_fault_o | output | 1 | One-cycle pulse: instruction length exceeded |

## Verification
Two cases are hard to reach from the ports. One is the length limit, which needs a run of 15 or 16 back-to-back prefix bytes with no gap. The other is the order-sensitive discard of an extension byte, which shows up only when a legacy prefix comes after it. The bench fills a byte array and plays it out in consecutive cycles to reach both: exactly 14 and 15 prefixes before the opcode, extension-then-66H and 66H-then-extension, and two extension bytes in a row. It also places prefix-valued bytes right after an opcode to confirm they are ignored.

// File: rtl/pfx_dec_pkg.sv
package pfx_dec_pkg;

  typedef enum logic [1:0] {
    MODE_LEGACY = 2'b00,
    MODE_COMPAT = 2'b01,
    MODE_LONG   = 2'b10
  } cpu_mode_e;

  typedef enum logic [1:0] {
    SZ_NONE = 2'b00,
    SZ_16   = 2'b01,
    SZ_32   = 2'b10,
    SZ_64   = 2'b11
  } size_e;

  typedef struct packed {
    logic w;
    logic r;
    logic x;
    logic b;
  } ext_bits_t;

  typedef struct packed {
    logic      opsz;
    logic      adsz;
    logic      ext_vld;
    ext_bits_t ext;
  } pfx_state_t;

endpackage

// File: rtl/pfx_byte_class.sv
module pfx_byte_class (
  input  logic [7:0] byte_i,
  input  logic       long_i,
  output logic       is_legacy_o,
  output logic       is_opsz_o,
  output logic       is_adsz_o,
  output logic       is_ext_o
);

  always_comb begin
    is_opsz_o = (byte_i == 8'h66);
    is_adsz_o = (byte_i == 8'h67);
    case (byte_i)
      8'h66, 8'h67, 8'hF0, 8'hF2, 8'hF3,
      8'h26, 8'h2E, 8'h36, 8'h3E, 8'h64, 8'h65: is_legacy_o = 1'b1;
      default:                                  is_legacy_o = 1'b0;
    endcase
    is_ext_o = long_i && (byte_i[7:4] == 4'h4);
  end

endmodule

// File: rtl/pfx_scan.sv
module pfx_scan
  import pfx_dec_pkg::*;
#(
  parameter int MAX_LEN = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       vld_i,
  input  logic       sop_i,
  input  logic [3:0] low_nib_i,
  input  logic       is_legacy_i,
  input  logic       is_opsz_i,
  input  logic       is_adsz_i,
  input  logic       is_ext_i,
  output pfx_state_t st_o,
  output logic       opc_evt_o,
  output logic       fault_evt_o
);

  localparam int CNT_W = $clog2(MAX_LEN + 1);
  localparam logic [CNT_W-1:0] CNT_LIM = CNT_W'(MAX_LEN);

  pfx_state_t       st_q, st_n, st_base;
  logic [CNT_W-1:0] cnt_q, cnt_n, cnt_base;
  logic             act_q, act_n, act_base;

  always_comb begin
    st_base  = sop_i ? '0 : st_q;
    cnt_base = sop_i ? '0 : cnt_q;
    act_base = sop_i ? 1'b1 : act_q;
    st_n        = st_q;
    cnt_n       = cnt_q;
    act_n       = act_q;
    opc_evt_o   = 1'b0;
    fault_evt_o = 1'b0;
    if (vld_i && act_base) begin
      st_n  = st_base;
      cnt_n = cnt_base;
      act_n = 1'b1;
      if (cnt_base == CNT_LIM) begin
        fault_evt_o = 1'b1;
        act_n       = 1'b0;
      end else if (is_legacy_i) begin
        st_n.opsz    = st_base.opsz | is_opsz_i;
        st_n.adsz    = st_base.adsz | is_adsz_i;
        st_n.ext_vld = 1'b0;
        st_n.ext     = '0;
        cnt_n        = cnt_base + 1'b1;
      end else if (is_ext_i) begin
        st_n.ext_vld = 1'b1;
        st_n.ext     = low_nib_i;
        cnt_n        = cnt_base + 1'b1;
      end else begin
        opc_evt_o = 1'b1;
        act_n     = 1'b0;
        cnt_n     = cnt_base + 1'b1;
      end
    end
  end

  assign st_o = st_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= '0;
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (vld_i) begin
      st_q  <= st_n;
      cnt_q <= cnt_n;
      act_q <= act_n;
    end
  end

  // R8
  len_fault_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_evt_o |-> (cnt_q == CNT_LIM) && !sop_i);

  // R9
  idle_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!act_q && !sop_i) |=> $stable(cnt_q));

endmodule

// File: rtl/pfx_size_resolve.sv
module pfx_size_resolve
  import pfx_dec_pkg::*;
(
  input  logic       [1:0] mode_i,
  input  logic             stack_i,
  input  pfx_state_t       st_i,
  output ext_bits_t        ext_o,
  output logic       [1:0] opnd_o,
  output logic       [1:0] addr_o
);

  logic long_mode;
  logic wide;

  always_comb begin
    long_mode = (mode_i == MODE_LONG);
    wide      = long_mode && st_i.ext_vld && st_i.ext.w;
    ext_o     = (long_mode && st_i.ext_vld) ? st_i.ext : '0;
    if (long_mode) begin
      if (wide)              opnd_o = SZ_64;
      else if (st_i.opsz)    opnd_o = SZ_16;
      else if (stack_i)      opnd_o = SZ_64;
      else                   opnd_o = SZ_32;
      addr_o = st_i.adsz ? SZ_32 : SZ_64;
    end else begin
      opnd_o = st_i.opsz ? SZ_16 : SZ_32;
      addr_o = st_i.adsz ? SZ_16 : SZ_32;
    end
  end

endmodule

// File: rtl/pfx_size_decoder.sv
module pfx_size_decoder
  import pfx_dec_pkg::*;
#(
  parameter int MAX_LEN = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       byte_vld_i,
  input  logic       byte_sop_i,
  input  logic [7:0] byte_i,
  input  logic [1:0] cpu_mode_i,
  input  logic       stack_op_i,
  output logic       rex_w_o,
  output logic       rex_r_o,
  output logic       rex_x_o,
  output logic       rex_b_o,
  output logic [1:0] opnd_size_o,
  output logic [1:0] addr_size_o,
  output logic       opc_stb_o,
  output logic       len_fault_o
);

  logic       is_legacy, is_opsz, is_adsz, is_ext;
  pfx_state_t st_cur;
  logic       opc_evt, fault_evt;
  ext_bits_t  ext_n, ext_q;
  logic [1:0] opnd_n, addr_n, opnd_q, addr_q;
  logic       stb_q, flt_q;

  pfx_byte_class u_class (
    .byte_i      (byte_i),
    .long_i      (cpu_mode_i == MODE_LONG),
    .is_legacy_o (is_legacy),
    .is_opsz_o   (is_opsz),
    .is_adsz_o   (is_adsz),
    .is_ext_o    (is_ext)
  );

  pfx_scan #(.MAX_LEN(MAX_LEN)) u_scan (
    .clk         (clk),
    .rst_n       (rst_n),
    .vld_i       (byte_vld_i),
    .sop_i       (byte_sop_i),
    .low_nib_i   (byte_i[3:0]),
    .is_legacy_i (is_legacy),
    .is_opsz_i   (is_opsz),
    .is_adsz_i   (is_adsz),
    .is_ext_i    (is_ext),
    .st_o        (st_cur),
    .opc_evt_o   (opc_evt),
    .fault_evt_o (fault_evt)
  );

  pfx_size_resolve u_resolve (
    .mode_i  (cpu_mode_i),
    .stack_i (stack_op_i),
    .st_i    (st_cur),
    .ext_o   (ext_n),
    .opnd_o  (opnd_n),
    .addr_o  (addr_n)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_q  <= '0;
      opnd_q <= SZ_32;
      addr_q <= SZ_32;
    end else if (opc_evt) begin
      ext_q  <= ext_n;
      opnd_q <= opnd_n;
      addr_q <= addr_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q <= 1'b0;
      flt_q <= 1'b0;
    end else begin
      stb_q <= opc_evt;
      flt_q <= fault_evt;
    end
  end

  assign rex_w_o     = ext_q.w;
  assign rex_r_o     = ext_q.r;
  assign rex_x_o     = ext_q.x;
  assign rex_b_o     = ext_q.b;
  assign opnd_size_o = opnd_q;
  assign addr_size_o = addr_q;
  assign opc_stb_o   = stb_q;
  assign len_fault_o = flt_q;

  // R8
  stb_fault_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(opc_stb_o && len_fault_o));

  // R3
  long_addr_no16_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (opc_stb_o && $past(cpu_mode_i) == MODE_LONG) |-> addr_size_o != SZ_16);

  // R7
  stack_no32_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (opc_stb_o && $past(cpu_mode_i) == MODE_LONG && $past(stack_op_i))
      |-> opnd_size_o != SZ_32);

  // R6
  legacy_ext_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (opc_stb_o && $past(cpu_mode_i) != MODE_LONG)
      |-> {rex_w_o, rex_r_o, rex_x_o, rex_b_o} == 4'b0000);

endmodule

// File: tb/pfx_size_decoder_bench.sv
module pfx_size_decoder_bench;

  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] LEG = 2'b00, CMP = 2'b01, LNG = 2'b10;
  localparam logic [1:0] S16 = 2'b01, S32 = 2'b10, S64 = 2'b11;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       vld, sop, stk;
  logic [7:0] din;
  logic [1:0] mode;
  logic       rw, rr, rx, rb, stb, flt;
  logic [1:0] opsz, adsz;

  int total = 0;
  int bad   = 0;
  logic [7:0] seq [0:19];

  always #(CLK_PERIOD/2) clk = ~clk;

  pfx_size_decoder u_pfx_size_decoder (
    .clk(clk), .rst_n(rst_n), .byte_vld_i(vld), .byte_sop_i(sop),
    .byte_i(din), .cpu_mode_i(mode), .stack_op_i(stk),
    .rex_w_o(rw), .rex_r_o(rr), .rex_x_o(rx), .rex_b_o(rb),
    .opnd_size_o(opsz), .addr_size_o(adsz),
    .opc_stb_o(stb), .len_fault_o(flt)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic issue(input int n, input logic s);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      vld = 1'b1; sop = (i == 0); din = seq[i]; stk = s;
    end
    @(negedge clk);
    vld = 1'b0; sop = 1'b0; stk = 1'b0;
  endtask

  task automatic expect_dec(input string tag, input logic [3:0] ext,
                            input logic [1:0] o, input logic [1:0] a);
    check({tag, " strobe"}, {7'd0, stb}, 8'd1);
    check({tag, " fault"},  {7'd0, flt}, 8'd0);
    check({tag, " ext"},    {4'd0, rw, rr, rx, rb}, {4'd0, ext});
    check({tag, " opnd"},   {6'd0, opsz}, {6'd0, o});
    check({tag, " addr"},   {6'd0, adsz}, {6'd0, a});
  endtask

  task automatic t_reset;
    check("R1 strobe", {7'd0, stb}, 8'd0);
    check("R1 fault",  {7'd0, flt}, 8'd0);
    check("R1 ext",    {4'd0, rw, rr, rx, rb}, 8'd0);
  endtask

  task automatic t_defaults;
    mode = LNG; seq[0] = 8'h90; issue(1, 0); expect_dec("R2 long", 4'h0, S32, S64);
    mode = LEG; seq[0] = 8'h90; issue(1, 0); expect_dec("R2 legacy", 4'h0, S32, S32);
    mode = CMP; seq[0] = 8'h01; issue(1, 0); expect_dec("R2 compat", 4'h0, S32, S32);
  endtask

  task automatic t_size_pfx;
    mode = LNG; seq[0] = 8'h66; seq[1] = 8'h67; seq[2] = 8'h01;
    issue(3, 0); expect_dec("R3 long 66 67", 4'h0, S16, S32);
    mode = LEG; issue(3, 0); expect_dec("R3 legacy 66 67", 4'h0, S16, S16);
    mode = LNG; seq[0] = 8'h2E; seq[1] = 8'h67; seq[2] = 8'h8B;
    issue(3, 0); expect_dec("R3 long seg 67", 4'h0, S32, S32);
  endtask

  task automatic t_ext;
    mode = LNG;
    seq[0] = 8'h48; seq[1] = 8'h01; issue(2, 0); expect_dec("R4 W", 4'h8, S64, S64);
    seq[0] = 8'h66; seq[1] = 8'h4F; seq[2] = 8'h01; issue(3, 0);
    expect_dec("R4 W over 66", 4'hF, S64, S64);
    seq[0] = 8'h45; seq[1] = 8'h8B; issue(2, 0); expect_dec("R4 R B", 4'h5, S32, S64);
    seq[0] = 8'h42; seq[1] = 8'h8B; issue(2, 0); expect_dec("R4 X", 4'h2, S32, S64);
  endtask

  task automatic t_ext_discard;
    mode = LNG;
    seq[0] = 8'h48; seq[1] = 8'h66; seq[2] = 8'h01; issue(3, 0);
    expect_dec("R5 ext then 66", 4'h0, S16, S64);
    seq[0] = 8'h41; seq[1] = 8'h4C; seq[2] = 8'h01; issue(3, 0);
    expect_dec("R5 last ext wins", 4'hC, S64, S64);
    seq[0] = 8'h4F; seq[1] = 8'hF3; seq[2] = 8'hA4; issue(3, 0);
    expect_dec("R5 ext then F3", 4'h0, S32, S64);
  endtask

  task automatic t_legacy_4x;
    mode = LEG; seq[0] = 8'h48; issue(1, 0);
    expect_dec("R6 legacy 48 opcode", 4'h0, S32, S32);
    mode = CMP; seq[0] = 8'h66; seq[1] = 8'h41; issue(2, 0);
    expect_dec("R6 compat 41 opcode", 4'h0, S16, S32);
  endtask

  task automatic t_stack;
    mode = LNG;
    seq[0] = 8'h50; issue(1, 1); expect_dec("R7 stack default", 4'h0, S64, S64);
    seq[0] = 8'h66; seq[1] = 8'h50; issue(2, 1); expect_dec("R7 stack 66", 4'h0, S16, S64);
    seq[0] = 8'h48; seq[1] = 8'h66; seq[2] = 8'h50; issue(3, 1);
    expect_dec("R7 stack ext dropped", 4'h0, S16, S64);
    seq[0] = 8'h66; seq[1] = 8'h48; seq[2] = 8'h50; issue(3, 1);
    expect_dec("R7 stack W", 4'h8, S64, S64);
    mode = LEG; seq[0] = 8'h50; issue(1, 1); expect_dec("R7 legacy stack", 4'h0, S32, S32);
  endtask

  task automatic t_length;
    mode = LNG;
    for (int i = 0; i < 14; i++) seq[i] = 8'h66;
    seq[14] = 8'h90; issue(15, 0); expect_dec("R8 fifteen bytes ok", 4'h0, S16, S64);
    for (int i = 0; i < 15; i++) seq[i] = 8'hF0;
    seq[15] = 8'h90; issue(16, 0);
    check("R8 fault pulse", {7'd0, flt}, 8'd1);
    check("R8 no strobe", {7'd0, stb}, 8'd0);
    @(negedge clk);
    check("R8 fault one cycle", {7'd0, flt}, 8'd0);
    for (int i = 0; i < 15; i++) seq[i] = 8'h67;
    seq[15] = 8'h48; seq[16] = 8'h90; issue(17, 0);
    check("R8 opcode after fault ignored", {7'd0, stb}, 8'd0);
  endtask

  task automatic t_trailing;
    mode = LNG;
    @(negedge clk); vld = 1; sop = 1; din = 8'h90;
    @(negedge clk); sop = 0; din = 8'h66;
    check("R9 strobe next cycle", {7'd0, stb}, 8'd1);
    check("R9 opnd", {6'd0, opsz}, {6'd0, S32});
    @(negedge clk); din = 8'h48;
    check("R9 strobe one cycle", {7'd0, stb}, 8'd0);
    @(negedge clk); din = 8'h01;
    check("R9 trailing ignored", {6'd0, stb, flt}, 8'd0);
    @(negedge clk); vld = 0;
    check("R9 trailing opcode ignored", {6'd0, stb, flt}, 8'd0);
    check("R9 outputs held", {6'd0, opsz}, {6'd0, S32});
  endtask

  task automatic t_sop_clear;
    mode = LNG;
    seq[0] = 8'h66; seq[1] = 8'h67; seq[2] = 8'h4B; issue(3, 0);
    check("R10 no strobe partial", {7'd0, stb}, 8'd0);
    seq[0] = 8'h90; issue(1, 0);
    expect_dec("R10 state cleared", 4'h0, S32, S64);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; vld = 0; sop = 0; stk = 0; din = 8'h00; mode = LNG;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_defaults();
    t_size_pfx();
    t_ext();
    t_ext_discard();
    t_legacy_4x();
    t_stack();
    t_length();
    t_trailing();
    t_sop_clear();
    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule